// File: doc/BRIEF.md
# Modem Line Control and Status Unit

This unit holds the modem-side registers of a 16550-style serial port. A byte-wide register bus writes a control register that drives four modem outputs (request-to-send, data-terminal-ready and two general-purpose outputs). The same bus reads a status register that reports the current levels of four modem inputs (clear-to-send, data-set-ready, carrier detect, ring) and a sticky change flag for each of them.

Each input passes through a two-stage synchronizer before any change is detected. Changes on clear-to-send, data-set-ready and carrier detect set their flags on either edge. The ring flag is set only when ring goes from high to low. A status read in normal mode returns the register and then clears the four flags. A loopback bit in the control register reroutes the control outputs to the status read port, so software can test the path without external wiring. When the modem interrupt enable input is high and any flag is set, a request goes to the interrupt logic.

Top module: `modem_line_unit`

## Requirements
- R1: After reset a status read returns 0xB0 (carrier detect, data-set-ready and clear-to-send high, ring low, no flags), a control read returns 0x08, out_aux2 is 1 and out_rts, out_dtr and out_aux1 are 0.
- R2: The status byte is laid out as carrier detect bit 7, ring bit 6, data-set-ready bit 5, clear-to-send bit 4, with their flags at bits 3, 2, 1 and 0. A level change on clear-to-send, data-set-ready or carrier detect sets its flag, and the flag stays set until a status read clears it.
- R3: The ring flag (bit 2) is set when ring falls from 1 to 0 and not when it rises.
- R4: A status read in normal mode returns the register as it was before the read and then clears bits 3..0. A change that is detected in the same cycle as the read is kept.
- R5: The control register keeps only wdata bits 4..0 and reads back with bits 7..5 at zero. Its fields are DTR bit 0, RTS bit 1, AUX1 bit 2, AUX2 bit 3 and LOOP bit 4. The control register sits at address 4 and the status register at address 6.
- R6: While LOOP is set, a status read returns AUX2 as bit 7, AUX1 as bit 6, DTR as bit 5 and RTS as bit 4, with bits 3..0 at zero.
- R7: While LOOP is set, out_rts and out_dtr are 0. Otherwise out_rts, out_dtr, out_aux1 and out_aux2 follow their control bits one cycle after the write.
- R8: irq_req is 1 exactly when msi_en was high in the previous cycle and at least one of the status bits 3..0 is set.
- R9: A status read in loopback mode leaves the flags unchanged. The external inputs keep being sampled and flagged during loopback.
- R10: A change on an input becomes visible in a status read issued four or more cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, held between reads |
| msi_en | input | 1 | Modem-status interrupt enable |
| pin_cts | input | 1 | Clear-to-send input (asynchronous) |
| pin_dsr | input | 1 | Data-set-ready input (asynchronous) |
| pin_dcd | input | 1 | Carrier-detect input (asynchronous) |
| pin_ri | input | 1 | Ring input (asynchronous) |
| out_rts | output | 1 | Request-to-send output |
| out_dtr | output | 1 | Data-terminal-ready output |
| out_aux1 | output | 1 | General-purpose output 1 |
| out_aux2 | output | 1 | General-purpose output 2 |
| irq_req | output | 1 | Modem-status interrupt request |

## Verification
The inputs are toggled one at a time, in pairs, and with a rising ring edge followed by a falling one. This separates the either-edge flags from the fall-only ring flag and shows that each flag maps to its own bit. Reads are placed both well after a change and in the same cycle the change is detected, which shows whether clear-on-read drops a new event. Loopback is run with several control patterns so that each crossed bit pairing is visible, and an input change made during loopback shows that a loopback read leaves the flags alone.

// File: rtl/modem_pkg.sv
package modem_pkg;
  // status nibble positions (upper nibble = levels, lower = flags)
  localparam int ST_CTS = 0;
  localparam int ST_DSR = 1;
  localparam int ST_RI  = 2;
  localparam int ST_DCD = 3;
  // control bit positions
  localparam int CT_DTR  = 0;
  localparam int CT_RTS  = 1;
  localparam int CT_AUX1 = 2;
  localparam int CT_AUX2 = 3;
  localparam int CT_LOOP = 4;
  localparam int CTRL_W  = 5;
  localparam int LINES   = 4;
  localparam logic [LINES-1:0]  LVL_RST  = 4'b1011;
  localparam logic [CTRL_W-1:0] CTRL_RST = 5'b01000;
endpackage

// File: rtl/modem_pin_sync.sv
module modem_pin_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= d_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RST_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/modem_delta_track.sv
module modem_delta_track
  import modem_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] line_i,
  input  logic             clr_i,
  output logic [LINES-1:0] lvl_o,
  output logic [LINES-1:0] flag_o,
  output logic [LINES-1:0] flag_nxt_o
);
  logic [LINES-1:0] lvl_q, flag_q, hit;

  always_comb begin
    hit = lvl_q ^ line_i;
    hit[ST_RI] = lvl_q[ST_RI] & ~line_i[ST_RI];
    flag_nxt_o = (clr_i ? '0 : flag_q) | hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q  <= LVL_RST;
      flag_q <= '0;
    end else begin
      lvl_q  <= line_i;
      flag_q <= flag_nxt_o;
    end
  end

  assign lvl_o  = lvl_q;
  assign flag_o = flag_q;

  // R3
  ri_fall_only_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag_q[ST_RI]) |-> ($past(lvl_q[ST_RI]) && !lvl_q[ST_RI]));
  // R2
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
  // R4
  clear_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_i && (line_i == lvl_q)) |=> (flag_q == '0));
endmodule

// File: rtl/modem_ctrl_reg.sv
module modem_ctrl_reg
  import modem_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic [7:0]        wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              rts_o,
  output logic              dtr_o,
  output logic              aux1_o,
  output logic              aux2_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;

  assign ctrl_nxt = we_i ? wdata_i[CTRL_W-1:0] : ctrl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= CTRL_RST;
      rts_o  <= 1'b0;
      dtr_o  <= 1'b0;
      aux1_o <= CTRL_RST[CT_AUX1];
      aux2_o <= CTRL_RST[CT_AUX2];
    end else begin
      ctrl_q <= ctrl_nxt;
      rts_o  <= ctrl_nxt[CT_RTS] & ~ctrl_nxt[CT_LOOP];
      dtr_o  <= ctrl_nxt[CT_DTR] & ~ctrl_nxt[CT_LOOP];
      aux1_o <= ctrl_nxt[CT_AUX1];
      aux2_o <= ctrl_nxt[CT_AUX2];
    end
  end

  assign ctrl_o = ctrl_q;

  // R7
  loop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CT_LOOP] |-> (!rts_o && !dtr_o));
endmodule

// File: rtl/modem_line_unit.sv
module modem_line_unit
  import modem_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int CTRL_ADDR = 4,
  parameter int STAT_ADDR = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              msi_en,
  input  logic              pin_cts,
  input  logic              pin_dsr,
  input  logic              pin_dcd,
  input  logic              pin_ri,
  output logic              out_rts,
  output logic              out_dtr,
  output logic              out_aux1,
  output logic              out_aux2,
  output logic              irq_req
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_ADDR);

  logic [LINES-1:0]  raw, synced, lvl, flag, flag_nxt;
  logic [CTRL_W-1:0] ctrl;
  logic              sel_ctrl, sel_stat, loop_on, clr_flags;
  logic [7:0]        stat_view, loop_view, rd_mux;

  assign raw[ST_CTS] = pin_cts;
  assign raw[ST_DSR] = pin_dsr;
  assign raw[ST_RI]  = pin_ri;
  assign raw[ST_DCD] = pin_dcd;

  assign sel_ctrl  = (bus_addr == A_CTRL);
  assign sel_stat  = (bus_addr == A_STAT);
  assign loop_on   = ctrl[CT_LOOP];
  assign clr_flags = bus_rd & sel_stat & ~loop_on;

  modem_pin_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(LVL_RST)) u_sync (
    .clk(clk), .rst(rst), .d_i(raw), .q_o(synced));

  modem_delta_track u_track (
    .clk(clk), .rst(rst), .line_i(synced), .clr_i(clr_flags),
    .lvl_o(lvl), .flag_o(flag), .flag_nxt_o(flag_nxt));

  modem_ctrl_reg u_ctrl (
    .clk(clk), .rst(rst), .we_i(bus_wr & sel_ctrl), .wdata_i(bus_wdata),
    .ctrl_o(ctrl), .rts_o(out_rts), .dtr_o(out_dtr),
    .aux1_o(out_aux1), .aux2_o(out_aux2));

  always_comb begin
    stat_view = {lvl, flag};
    loop_view = '0;
    loop_view[4 + ST_DCD] = ctrl[CT_AUX2];
    loop_view[4 + ST_RI]  = ctrl[CT_AUX1];
    loop_view[4 + ST_DSR] = ctrl[CT_DTR];
    loop_view[4 + ST_CTS] = ctrl[CT_RTS];
    if (sel_ctrl)      rd_mux = 8'(ctrl);
    else if (sel_stat) rd_mux = loop_on ? loop_view : stat_view;
    else               rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_req   <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_mux;
      irq_req <= msi_en & (|flag_nxt);
    end
  end

  // R8
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (flag != '0));
  // R6
  loop_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_stat && loop_on) |=> (bus_rdata[3:0] == 4'h0));
  // R9
  loop_keeps_flags_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel_stat && loop_on) |=> ((flag & $past(flag)) == $past(flag)));
endmodule

// File: tb/sim_modem_line_unit.sv
module sim_modem_line_unit;
  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [2:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0, bus_rdata;
  logic msi_en = 0;
  logic pin_cts = 1, pin_dsr = 1, pin_dcd = 1, pin_ri = 0;
  logic out_rts, out_dtr, out_aux1, out_aux2, irq_req;

  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  modem_line_unit u0 (.*);

  // behavioural reference: nibble order {dcd, ri, dsr, cts}
  logic [3:0] m_p1, m_p2, m_lvl, m_flg;
  logic [4:0] m_ctl;
  logic [7:0] m_rd;
  logic m_irq, m_rts, m_dtr, m_a1, m_a2;

  always @(posedge clk) begin
    if (rst) begin
      m_p1 = 4'b1011; m_p2 = 4'b1011; m_lvl = 4'b1011; m_flg = 0;
      m_ctl = 5'h08; m_rd = 0; m_irq = 0;
    end else begin
      logic [3:0] nf, chg;
      bit rs;
      rs = bus_rd && bus_addr == 6;
      if (bus_rd) begin
        if (bus_addr == 4) m_rd = {3'b0, m_ctl};
        else if (rs) m_rd = m_ctl[4] ? {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1], 4'h0}
                                     : {m_lvl, m_flg};
        else m_rd = 0;
      end
      chg = m_lvl ^ m_p2;
      chg[2] = m_lvl[2] && !m_p2[2];
      nf = ((rs && !m_ctl[4]) ? 4'h0 : m_flg) | chg;
      m_flg = nf;
      m_irq = msi_en && nf != 0;
      m_lvl = m_p2; m_p2 = m_p1; m_p1 = {pin_dcd, pin_ri, pin_dsr, pin_cts};
      if (bus_wr && bus_addr == 4) m_ctl = bus_wdata[4:0];
    end
    m_rts = m_ctl[1] && !m_ctl[4];
    m_dtr = m_ctl[0] && !m_ctl[4];
    m_a1 = m_ctl[2];
    m_a2 = m_ctl[3];
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst && !done) begin
    chk("R4 model rdata", bus_rdata, m_rd);
    chk("R8 model irq", {7'b0, irq_req}, {7'b0, m_irq});
    chk("R7 model pins", {4'b0, out_rts, out_dtr, out_aux1, out_aux2},
        {4'b0, m_rts, m_dtr, m_a1, m_a2});
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd(logic [2:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1; bus_addr = a;
    @(negedge clk); bus_rd = 0; v = bus_rdata;
  endtask

  initial begin
    logic [7:0] v;
    idle(3); @(negedge clk); rst = 0;
    // R1
    rd(6, v); chk("R1 status", v, 8'hB0);
    rd(4, v); chk("R1 ctrl", v, 8'h08);
    chk("R1 pins", {out_rts, out_dtr, out_aux1, out_aux2}, 8'h01);
    // R2 / R10: CTS drop
    pin_cts = 0; idle(4);
    rd(6, v); chk("R2 R10 cts flag", v, 8'hA1);
    rd(6, v); chk("R4 cleared", v, 8'hA0);
    // R3: ring rise then fall
    pin_ri = 1; idle(5);
    rd(6, v); chk("R3 ri rise no flag", v, 8'hE0);
    pin_ri = 0; idle(5);
    rd(6, v); chk("R3 ri fall flag", v, 8'hA4);
    // R2: two lines together, R8 interrupt
    msi_en = 1; pin_dsr = 0; pin_dcd = 0; idle(5);
    chk("R8 irq on", {7'b0, irq_req}, 8'h01);
    msi_en = 0; idle(2);
    chk("R8 irq masked", {7'b0, irq_req}, 8'h00);
    rd(6, v); chk("R2 dsr dcd", v, 8'h0A);
    // R4: change detected in the same cycle as a read
    @(negedge clk); pin_cts = 1; idle(2);
    bus_rd = 1; bus_addr = 6; @(negedge clk); bus_rd = 0;
    chk("R4 old value", bus_rdata, 8'h00);
    rd(6, v); chk("R4 change kept", v, 8'h11);
    // R5 / R6 / R7
    wr(4, 8'hFF); rd(4, v); chk("R5 ctrl mask", v, 8'h1F);
    chk("R7 loop pins", {out_rts, out_dtr, out_aux1, out_aux2}, 8'h03);
    rd(6, v); chk("R6 loop all", v, 8'hF0);
    wr(4, 8'h15); rd(6, v); chk("R6 aux1 dtr", v, 8'h60);
    wr(4, 8'h1A); rd(6, v); chk("R6 aux2 rts", v, 8'h90);
    // R9: change during loopback survives a loopback read
    pin_cts = 0; idle(5);
    rd(6, v); chk("R9 loop read", v, 8'h90);
    wr(4, 8'h03);
    chk("R7 normal pins", {out_rts, out_dtr, out_aux1, out_aux2}, 8'h0C);
    rd(6, v); chk("R9 flag kept", v, 8'h01);
    idle(3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1; total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule